// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block turns an in-memory list of scatter-gather descriptors into a stream of segment commands for a downstream data fetcher. Each descriptor takes 8 bytes: a length word at byte offset 0 and an address word at byte offset 4. Entry `i` sits at `base + 8*i`. For every entry the walker reads the length word and then the address word over a single-outstanding word-read port. It then presents one segment command (address, byte count, last flag) on a valid/ready output.

A walk begins with a one-cycle `start_i` pulse, which samples `base_i`. The walk ends normally once the segment whose length word has bit 31 set has been accepted downstream. If `MAX_ENTRIES` segments go out and none carries the marker, the walk ends with an error instead, and the walker reads no further entry. In both cases a one-cycle `done_o` pulse reports the end, with `err_o` alongside it, and the walker goes back to idle.

Top module: `sg_walker`

## Requirements
- R1: While reset is held and after its release, with no start, `busy_o`, `mem_req_o`, `seg_valid_o` and `done_o` are all 0.
- R2: For entry `i` the walker first requests the word at `base + 8*i` (modulo 2^32), then the word at `base + 8*i + 4`. Each request keeps `mem_req_o` high and `mem_addr_o` unchanged until the cycle in which `mem_rvalid_i` is high.
- R3: `seg_len_o` equals bits [27:0] of the length word and `seg_last_o` equals its bit 31. Bits [30:28] have no effect on any output.
- R4: `seg_addr_o` equals the address word with bit 31 forced to 0.
- R5: While `seg_valid_o` is high and `seg_ready_i` is low, the segment fields stay unchanged and no memory read is requested.
- R6: In the cycle after a segment with the last flag is accepted, `done_o` is 1 and `err_o` is 0, and no memory read is requested. In the following cycle `done_o` and `busy_o` are 0.
- R7: If `MAX_ENTRIES` segments are accepted and none has the last flag, the walker emits `done_o` with `err_o` = 1 in the next cycle. It never requests a word of entry `MAX_ENTRIES`.
- R8: A `start_i` pulse while a walk is in progress is ignored. The walk keeps its original base and does not restart once it ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (accepted only when idle) |
| base_i | input | ADDR_W | Byte address of descriptor 0, sampled on start |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Word read request, held until completed |
| mem_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_rvalid_i | input | 1 | Read completion; data valid this cycle |
| mem_rdata_i | input | 32 | Read data, little-endian (lowest byte address in bits [7:0]) |
| seg_valid_o | output | 1 | Segment command valid |
| seg_ready_i | input | 1 | Downstream accepts the segment |
| seg_addr_o | output | ADDR_W | Segment byte address |
| seg_len_o | output | LEN_W | Segment byte count |
| seg_last_o | output | 1 | Segment is the final one of the list |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| err_o | output | 1 | With done_o: list ended without a last marker |

## Verification
The assertions take for granted that the memory side raises `mem_rvalid_i` only during a cycle in which `mem_req_o` is high, and never more than once per request. They also assume `start_i` is a single-cycle pulse. The stimulus plays the memory and the downstream fetcher in one sequential task. That task returns exactly one completion per observed request, after a delay of zero to two cycles, and it drops `seg_ready_i` again after each handshake. Start pulses are one cycle wide. The only start issued during a walk is the deliberate one that tests R8.

// File: rtl/sg_walker_pkg.sv
package sg_walker_pkg;
  localparam int WORD_W    = 32;
  localparam int LAST_POS  = 31;
  localparam int DESC_STEP = 8;
  localparam int ADR_OFF   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LEN,
    ST_RD_ADR,
    ST_SEND,
    ST_DONE
  } sg_state_e;
endpackage

// File: rtl/sg_walker_idx.sv
module sg_walker_idx #(
  parameter int MAX_ENTRIES = 16,
  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             at_limit_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (inc_i) idx_q <= idx_q + 1'b1;
  end

  assign idx_o      = idx_q;
  assign at_limit_o = (idx_q == IDX_W'(MAX_ENTRIES - 1));
endmodule

// File: rtl/sg_walker_desc.sv
module sg_walker_desc
  import sg_walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_len_i,
  input  logic              ld_adr_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] adr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              last_o
);
  localparam logic [WORD_W-1:0] ADR_MASK = ~(WORD_W'(1) << LAST_POS);

  logic [WORD_W-1:0] adr_m;
  logic [ADDR_W-1:0] adr_q;
  logic [LEN_W-1:0]  len_q;
  logic              last_q;

  assign adr_m = rdata_i & ADR_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      last_q <= 1'b0;
    end else if (ld_len_i) begin
      len_q  <= rdata_i[LEN_W-1:0];
      last_q <= rdata_i[LAST_POS];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       adr_q <= '0;
    else if (ld_adr_i) adr_q <= adr_m[ADDR_W-1:0];
  end

  assign adr_o  = adr_q;
  assign len_o  = len_q;
  assign last_o = last_q;
endmodule

// File: rtl/sg_walker_ctrl.sv
module sg_walker_ctrl
  import sg_walker_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      rvalid_i,
  input  logic      seg_ready_i,
  input  logic      last_i,
  input  logic      at_limit_i,
  output sg_state_e state_o,
  output logic      base_ld_o,
  output logic      ld_len_o,
  output logic      ld_adr_o,
  output logic      idx_clr_o,
  output logic      idx_inc_o,
  output logic      err_o
);
  sg_state_e state_q, state_d;
  logic      err_q, err_d;

  always_comb begin
    state_d   = state_q;
    err_d     = err_q;
    base_ld_o = 1'b0;
    ld_len_o  = 1'b0;
    ld_adr_o  = 1'b0;
    idx_clr_o = 1'b0;
    idx_inc_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        base_ld_o = 1'b1;
        idx_clr_o = 1'b1;
        err_d     = 1'b0;
        state_d   = ST_RD_LEN;
      end
      ST_RD_LEN: if (rvalid_i) begin
        ld_len_o = 1'b1;
        state_d  = ST_RD_ADR;
      end
      ST_RD_ADR: if (rvalid_i) begin
        ld_adr_o = 1'b1;
        state_d  = ST_SEND;
      end
      ST_SEND: if (seg_ready_i) begin
        if (last_i) begin
          state_d = ST_DONE;
        end else if (at_limit_i) begin
          err_d   = 1'b1;
          state_d = ST_DONE;
        end else begin
          idx_inc_o = 1'b1;
          state_d   = ST_RD_LEN;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sg_walker_pkg::*;
#(
  parameter int MAX_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 28,
  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              seg_valid_o,
  input  logic              seg_ready_i,
  output logic [ADDR_W-1:0] seg_addr_o,
  output logic [LEN_W-1:0]  seg_len_o,
  output logic              seg_last_o,
  output logic              done_o,
  output logic              err_o
);
  sg_state_e         state;
  logic              base_ld, ld_len, ld_adr, idx_clr, idx_inc, at_limit;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base_q, ent_off, word_off;

  sg_walker_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rvalid_i    (mem_rvalid_i),
    .seg_ready_i (seg_ready_i),
    .last_i      (seg_last_o),
    .at_limit_i  (at_limit),
    .state_o     (state),
    .base_ld_o   (base_ld),
    .ld_len_o    (ld_len),
    .ld_adr_o    (ld_adr),
    .idx_clr_o   (idx_clr),
    .idx_inc_o   (idx_inc),
    .err_o       (err_o)
  );

  sg_walker_idx #(.MAX_ENTRIES(MAX_ENTRIES)) u_idx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (idx_clr),
    .inc_i      (idx_inc),
    .idx_o      (idx),
    .at_limit_o (at_limit)
  );

  sg_walker_desc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_desc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_len_i (ld_len),
    .ld_adr_i (ld_adr),
    .rdata_i  (mem_rdata_i),
    .adr_o    (seg_addr_o),
    .len_o    (seg_len_o),
    .last_o   (seg_last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      base_q <= '0;
    else if (base_ld) base_q <= base_i;
  end

  // entry stride is 8 bytes; address word sits 4 bytes in
  assign ent_off    = ADDR_W'({idx, 3'b000});
  assign word_off   = (state == ST_RD_ADR) ? ADDR_W'(ADR_OFF) : '0;
  assign mem_addr_o = base_q + ent_off + word_off;
  assign mem_req_o  = (state == ST_RD_LEN) || (state == ST_RD_ADR);
  assign seg_valid_o = (state == ST_SEND);
  assign done_o     = (state == ST_DONE);
  assign busy_o     = (state != ST_IDLE);
endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
  parameter int MAX_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 28,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic              seg_valid_o,
  input logic              seg_ready_i,
  input logic [ADDR_W-1:0] seg_addr_o,
  input logic [LEN_W-1:0]  seg_len_o,
  input logic              seg_last_o,
  input logic              done_o,
  input logic              err_o
);
  logic [CNT_W-1:0] acc_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         acc_cnt <= '0;
    else if (done_o)                     acc_cnt <= '0;
    else if (seg_valid_o && seg_ready_i) acc_cnt <= acc_cnt + 1'b1;
  end

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R5
  seg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_valid_o && !seg_ready_i) |=>
      (seg_valid_o && $stable(seg_addr_o) && $stable(seg_len_o) && $stable(seg_last_o)));

  // R5
  no_read_in_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o |-> !mem_req_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(seg_valid_o && seg_ready_i));

  // R6
  last_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_valid_o && seg_ready_i && seg_last_o) |=> (done_o && !err_o));

  // R7
  seg_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_cnt <= CNT_W'(MAX_ENTRIES));

  // R7
  err_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (acc_cnt == CNT_W'(MAX_ENTRIES)));
endmodule

bind sg_walker sg_walker_chk #(
  .MAX_ENTRIES (MAX_ENTRIES),
  .ADDR_W      (ADDR_W),
  .LEN_W       (LEN_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .seg_valid_o  (seg_valid_o),
  .seg_ready_i  (seg_ready_i),
  .seg_addr_o   (seg_addr_o),
  .seg_len_o    (seg_len_o),
  .seg_last_o   (seg_last_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/sg_walker_bench.sv
`timescale 1ns/1ps
module sg_walker_bench;
  localparam int MAX = 5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic        busy_o, mem_req_o, mem_rvalid_i = 1'b0;
  logic [31:0] mem_addr_o, mem_rdata_i = '0;
  logic        seg_valid_o, seg_ready_i = 1'b0, seg_last_o, done_o, err_o;
  logic [31:0] seg_addr_o;
  logic [27:0] seg_len_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  sg_walker #(.MAX_ENTRIES(MAX), .ADDR_W(32), .LEN_W(28)) u_sg_walker (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .base_i(base_i),
    .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .seg_valid_o(seg_valid_o), .seg_ready_i(seg_ready_i),
    .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o), .seg_last_o(seg_last_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] len_word(input logic [31:0] b, input int n, input int i,
                                           input bit last);
    logic [27:0] l = 28'((i + 1) * 1234567 + n * 89 + int'(b[11:0]));
    logic [2:0]  junk = 3'(i + n + 1);
    return {last, junk, l};
  endfunction

  function automatic logic [31:0] adr_word(input logic [31:0] b, input int n, input int i);
    return {1'(i % 2), 31'(b * 3 + 32'(i) * 32'h1000 + 32'(n))};
  endfunction

  task automatic serve(input logic [31:0] exp_a, input logic [31:0] w, input int d,
                       input bit poke);
    int k = 0;
    while (!mem_req_o && k < 64) begin @(negedge clk); k++; end
    chk(mem_req_o == 1'b1, "R2 request", 64'(mem_req_o), 64'd1);
    chk(mem_addr_o == exp_a, "R2 address", 64'(mem_addr_o), 64'(exp_a));
    for (int j = 0; j < d; j++) begin
      if (poke && j == 0) begin start_i = 1'b1; base_i = 32'h5555_0000; end
      @(negedge clk);
      start_i = 1'b0;
      chk(mem_req_o && mem_addr_o == exp_a, "R2 hold", 64'(mem_addr_o), 64'(exp_a));
    end
    mem_rvalid_i = 1'b1;
    mem_rdata_i  = w;
    @(negedge clk);
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = '0;
  endtask

  task automatic run_walk(input logic [31:0] b, input int n, input bit has_last,
                          input bit poke);
    int cnt = has_last ? n : MAX;
    @(negedge clk);
    start_i = 1'b1;
    base_i  = b;
    @(negedge clk);
    start_i = 1'b0;
    base_i  = '0;
    chk(busy_o == 1'b1, "R2 busy", 64'(busy_o), 64'd1);
    for (int i = 0; i < cnt; i++) begin
      bit          last = has_last && (i == n - 1);
      logic [31:0] lw = len_word(b, n, i, last);
      logic [31:0] aw = adr_word(b, n, i);
      int          k = 0;
      serve(b + 32'(8 * i), lw, (i + n) % 3, poke && i == 0);
      serve(b + 32'(8 * i + 4), aw, (i + 2 * n) % 3, 1'b0);
      while (!seg_valid_o && k < 64) begin @(negedge clk); k++; end
      chk(seg_valid_o == 1'b1, "R5 valid", 64'(seg_valid_o), 64'd1);
      chk(seg_len_o == lw[27:0], "R3 length", 64'(seg_len_o), 64'(lw[27:0]));
      chk(seg_last_o == last, "R3 last", 64'(seg_last_o), 64'(last));
      chk(seg_addr_o == {1'b0, aw[30:0]}, "R4 address", 64'(seg_addr_o),
          64'({1'b0, aw[30:0]}));
      for (int j = 0; j < (2 * i + n) % 3; j++) begin
        @(negedge clk);
        chk(seg_valid_o && !mem_req_o && seg_len_o == lw[27:0] &&
            seg_addr_o == {1'b0, aw[30:0]}, "R5 stall",
            64'({seg_valid_o, mem_req_o}), 64'b10);
      end
      seg_ready_i = 1'b1;
      @(negedge clk);
      seg_ready_i = 1'b0;
    end
    if (has_last) begin
      chk(done_o && !err_o && !mem_req_o, "R6 done", 64'({done_o, err_o, mem_req_o}), 64'b100);
    end else begin
      chk(done_o && err_o && !mem_req_o, "R7 error", 64'({done_o, err_o, mem_req_o}), 64'b110);
    end
    @(negedge clk);
    chk(!done_o && !busy_o, "R6 idle", 64'({done_o, busy_o}), 64'b00);
    @(negedge clk);
    chk(!busy_o && !mem_req_o, "R8 no restart", 64'({busy_o, mem_req_o}), 64'b00);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R6 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] bases [3];
    bases[0] = 32'h0000_0000;
    bases[1] = 32'h1000_0040;
    bases[2] = 32'hFFFF_FFE8;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy_o && !mem_req_o && !seg_valid_o && !done_o, "R1 in reset",
        64'({busy_o, mem_req_o, seg_valid_o, done_o}), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !mem_req_o && !seg_valid_o && !done_o, "R1 after reset",
        64'({busy_o, mem_req_o, seg_valid_o, done_o}), 64'd0);
    for (int bi = 0; bi < 3; bi++) begin
      for (int n = 1; n <= MAX; n++) run_walk(bases[bi], n, 1'b1, 1'b0);
      run_walk(bases[bi], MAX, 1'b0, 1'b0);
    end
    // R8: start pulses during a walk must not alter the base
    run_walk(32'h0000_2000, 3, 1'b1, 1'b1);
    run_walk(32'h0000_3000, MAX, 1'b0, 1'b1);
    finish_run();
  end
endmodule